// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm

This block keeps the seconds, minutes and hours of a real-time-clock peripheral. A strobe from a 32 kHz time base drives an internal divider, and the time advances once every `TICKS_PER_SEC` strobes. Software reaches the block through a byte-wide register port with eight addresses:

| Address | Contents |
| --- | --- |
| 0 | seconds |
| 1 | seconds alarm |
| 2 | minutes |
| 3 | minutes alarm |
| 4 | hours |
| 5 | hours alarm |
| 6 | control A |
| 7 | control B |

Reads are combinational from `rd_addr`. Writes take effect at the clock edge on which `wr_en` is high.

Control A holds the divider field in bits 6:4 and the read-only update-in-progress flag in bit 7. Control B holds three mode bits:
- bit 7 freezes the time (SET).
- bit 2 selects binary storage when 1 and BCD when 0.
- bit 1 selects 24-hour format when 1 and 12-hour format when 0.

The time is held internally as binary values, with hours from 0 to 23. Each byte is converted to the current encoding when it is written and when it is read. Alarm bytes are kept exactly as written and are decoded under the current mode when they are compared. After each update the block raises one-cycle strobes: update complete, alarm match and day wrap.

Top module: `tod_clock_core`

## Requirements
- R1: After synchronous reset, the time is 00:00:00. Control A reads 0x20 and control B reads 0x02. All event strobes and `uip` are low.
- R2: When SET (B bit 7) is clear and the divider field (A[6:4]) is 0, 1 or 2, the time advances by one second every `TICKS_PER_SEC` tick strobes. Each advance gives a one-cycle pulse on `update_done`, which is visible in the cycle after the clock edge that applied it.
- R3: Seconds and minutes roll over from 59 to 0 and carry into the next field. Hours roll over from 23 to 0, and `day_wrap` pulses together with that update.
- R4: While SET is 1, the time does not advance and `update_done` stays low, and written time values are held. The divider keeps its phase, so after SET is cleared every update still falls a whole number of seconds after an update made before SET was set.
- R5: When A[6:5] is 11, the divider is held. No update or alarm occurs, `uip` reads 0 and the time is unchanged. After the divider field is written back to 2, the first update comes `TICKS_PER_SEC/2` ticks later.
- R6: `uip`, which also reads as A bit 7, is 1 for exactly the last `UIP_TICKS` ticks before each update. Writes to A bit 7 are ignored.
- R7: In BCD mode (B bit 2 = 0), a byte holds the tens digit in bits 7:4 and the units digit in bits 3:0. In binary mode (B bit 2 = 1), the byte holds the plain value. Changing the mode re-encodes the stored time when it is read.
- R8: In 12-hour mode (B bit 1 = 0), the hours byte holds 1 to 12 and bit 7 marks PM. Internal hour 0 reads as 12 AM, and hours 12 to 23 read with bit 7 set.
- R9: `alarm_hit` pulses with `update_done` when the new time matches every alarm byte that is not a wildcard. An alarm byte whose bits 7:6 are both 1 is a wildcard. Alarm bytes read back exactly as they were written.
- R10: The alarm hour and the current hour are both converted to the range 0 to 23 before they are compared. An alarm hour written as 2 PM in 12-hour mode therefore matches 14:00, and 2 AM does not.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_32k | input | 1 | One-cycle strobe from the 32 kHz time base |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| uip | output | 1 | Update-in-progress flag |
| update_done | output | 1 | One-cycle pulse after each seconds update |
| alarm_hit | output | 1 | One-cycle pulse when an update matches the alarm |
| day_wrap | output | 1 | One-cycle pulse when the hours wrap from 23 to 0 |

## Verification
The properties assume that `TICKS_PER_SEC` is at least 2 and larger than `UIP_TICKS`. They also assume that a write to control B is never applied on the same edge as an update. If that happened, a pulse computed under the old SET value could appear while SET already reads 1. The stimulus sets or clears SET only a few ticks after an observed update, well away from the next wrap of the divider. Time and alarm bytes are written only while SET is 1 or the divider is held, so every expected value comes from a known starting time.

// File: rtl/tod_pkg.sv
package tod_pkg;

    typedef struct packed {
        logic [4:0] hr;
        logic [5:0] min;
        logic [5:0] sec;
    } tod_t;

    typedef enum logic [2:0] {
        RA_SEC     = 3'd0,
        RA_SEC_ALM = 3'd1,
        RA_MIN     = 3'd2,
        RA_MIN_ALM = 3'd3,
        RA_HR      = 3'd4,
        RA_HR_ALM  = 3'd5,
        RA_CTLA    = 3'd6,
        RA_CTLB    = 3'd7
    } tod_addr_e;

    localparam logic [6:0] CTLA_RESET = 7'h20;
    localparam logic [7:0] CTLB_RESET = 8'h02;
    localparam int FREEZE_BIT = 7;
    localparam int BIN_BIT    = 2;
    localparam int H24_BIT    = 1;

    function automatic logic is_wild(input logic [7:0] b);
        return b[7] & b[6];
    endfunction

    function automatic logic [6:0] byte_to_val(input logic [7:0] b, input logic bin);
        logic [7:0] t;
        if (bin) return b[6:0];
        t = {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
        return t[6:0];
    endfunction

    function automatic logic [7:0] val_to_byte(input logic [6:0] v, input logic bin);
        logic [7:0] t, tens, ones;
        t = {1'b0, v};
        if (bin) return t;
        tens = t / 8'd10;
        ones = t % 8'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [4:0] hr_from_byte(input logic [7:0] b, input logic bin,
                                                input logic h24);
        logic [6:0] v;
        if (h24) begin
            v = byte_to_val(b, bin);
        end else begin
            v = byte_to_val({1'b0, b[6:0]}, bin) % 7'd12;
            if (b[7]) v = v + 7'd12;
        end
        return v[4:0];
    endfunction

    function automatic logic [7:0] hr_to_byte(input logic [4:0] h, input logic bin,
                                              input logic h24);
        logic [4:0] hh;
        logic [7:0] r;
        if (h24) return val_to_byte({2'b0, h}, bin);
        hh = (h >= 5'd12) ? h - 5'd12 : h;
        if (hh == 5'd0) hh = 5'd12;
        r = val_to_byte({2'b0, hh}, bin);
        r[7] = (h >= 5'd12);
        return r;
    endfunction

endpackage

// File: rtl/tod_divider.sv
module tod_divider #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic div_hold,
    input  logic div_run,
    input  logic frozen,
    output logic advance,
    output logic uip
);
    localparam int PW = $clog2(TICKS_PER_SEC);
    localparam logic [PW-1:0] LAST      = PW'(TICKS_PER_SEC - 1);
    localparam logic [PW-1:0] HALF      = PW'(TICKS_PER_SEC / 2);
    localparam logic [PW-1:0] UIP_START = PW'(TICKS_PER_SEC - UIP_TICKS);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (div_hold) begin
            phase <= HALF;
        end else if (tick && div_run) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    assign advance = tick && div_run && !frozen && (phase == LAST);
    assign uip     = div_run && !frozen && (phase >= UIP_START);

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    input  logic       wr_sec,
    input  logic       wr_min,
    input  logic       wr_hr,
    input  logic [6:0] wr_val,
    input  logic [4:0] wr_hr_val,
    output tod_t       now,
    output tod_t       next,
    output logic       wrap
);
    always_comb begin
        next = now;
        wrap = 1'b0;
        if (now.sec >= 6'd59) begin
            next.sec = '0;
            if (now.min >= 6'd59) begin
                next.min = '0;
                if (now.hr >= 5'd23) begin
                    next.hr = '0;
                    wrap    = 1'b1;
                end else begin
                    next.hr = now.hr + 1'b1;
                end
            end else begin
                next.min = now.min + 1'b1;
            end
        end else begin
            next.sec = now.sec + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
        end else begin
            if (advance) now <= next;
            if (wr_sec)  now.sec <= wr_val[5:0];
            if (wr_min)  now.min <= wr_val[5:0];
            if (wr_hr)   now.hr  <= wr_hr_val;
        end
    end

endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_sec,
    input  logic       wr_min,
    input  logic       wr_hr,
    input  logic [7:0] wr_data,
    input  logic       bin,
    input  logic       h24,
    input  tod_t       cand,
    output logic [7:0] alm_sec,
    output logic [7:0] alm_min,
    output logic [7:0] alm_hr,
    output logic       match
);
    logic sec_ok, min_ok, hr_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            alm_sec <= '0;
            alm_min <= '0;
            alm_hr  <= '0;
        end else begin
            if (wr_sec) alm_sec <= wr_data;
            if (wr_min) alm_min <= wr_data;
            if (wr_hr)  alm_hr  <= wr_data;
        end
    end

    always_comb begin
        sec_ok = is_wild(alm_sec) || (byte_to_val(alm_sec, bin) == {1'b0, cand.sec});
        min_ok = is_wild(alm_min) || (byte_to_val(alm_min, bin) == {1'b0, cand.min});
        hr_ok  = is_wild(alm_hr)  || (hr_from_byte(alm_hr, bin, h24) == cand.hr);
        match  = sec_ok && min_ok && hr_ok;
    end

endmodule

// File: rtl/tod_clock_core.sv
module tod_clock_core
    import tod_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_32k,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       uip,
    output logic       update_done,
    output logic       alarm_hit,
    output logic       day_wrap
);
    logic [6:0] ctla_q;
    logic [7:0] ctlb_q;
    logic       bin, h24, frozen, div_hold, div_run, advance, wrap, match;
    tod_t       now, next;
    logic [7:0] alm_sec, alm_min, alm_hr;
    tod_addr_e  wsel, rsel;

    assign wsel     = tod_addr_e'(wr_addr);
    assign rsel     = tod_addr_e'(rd_addr);
    assign bin      = ctlb_q[BIN_BIT];
    assign h24      = ctlb_q[H24_BIT];
    assign frozen   = ctlb_q[FREEZE_BIT];
    assign div_hold = ctla_q[6] & ctla_q[5];
    assign div_run  = ctla_q[6:4] <= 3'd2;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctla_q <= CTLA_RESET;
            ctlb_q <= CTLB_RESET;
        end else if (wr_en) begin
            if (wsel == RA_CTLA) ctla_q <= wr_data[6:0];
            if (wsel == RA_CTLB) ctlb_q <= wr_data;
        end
    end

    tod_divider #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .UIP_TICKS    (UIP_TICKS)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_32k),
        .div_hold(div_hold),
        .div_run (div_run),
        .frozen  (frozen),
        .advance (advance),
        .uip     (uip)
    );

    tod_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .wr_sec   (wr_en && wsel == RA_SEC),
        .wr_min   (wr_en && wsel == RA_MIN),
        .wr_hr    (wr_en && wsel == RA_HR),
        .wr_val   (byte_to_val(wr_data, bin)),
        .wr_hr_val(hr_from_byte(wr_data, bin, h24)),
        .now      (now),
        .next     (next),
        .wrap     (wrap)
    );

    tod_alarm u_alm (
        .clk    (clk),
        .rst    (rst),
        .wr_sec (wr_en && wsel == RA_SEC_ALM),
        .wr_min (wr_en && wsel == RA_MIN_ALM),
        .wr_hr  (wr_en && wsel == RA_HR_ALM),
        .wr_data(wr_data),
        .bin    (bin),
        .h24    (h24),
        .cand   (next),
        .alm_sec(alm_sec),
        .alm_min(alm_min),
        .alm_hr (alm_hr),
        .match  (match)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            update_done <= 1'b0;
            alarm_hit   <= 1'b0;
            day_wrap    <= 1'b0;
        end else begin
            update_done <= advance;
            alarm_hit   <= advance && match;
            day_wrap    <= advance && wrap;
        end
    end

    always_comb begin
        case (rsel)
            RA_SEC:     rd_data = val_to_byte({1'b0, now.sec}, bin);
            RA_SEC_ALM: rd_data = alm_sec;
            RA_MIN:     rd_data = val_to_byte({1'b0, now.min}, bin);
            RA_MIN_ALM: rd_data = alm_min;
            RA_HR:      rd_data = hr_to_byte(now.hr, bin, h24);
            RA_HR_ALM:  rd_data = alm_hr;
            RA_CTLA:    rd_data = {uip, ctla_q};
            default:    rd_data = ctlb_q;
        endcase
    end

endmodule

// File: rtl/tod_clock_core_chk.sv
module tod_clock_core_chk (
    input logic clk,
    input logic rst,
    input logic frozen,
    input logic div_hold,
    input logic uip,
    input logic update_done,
    input logic alarm_hit,
    input logic day_wrap
);
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        update_done |=> !update_done);

    p_day_with_update_r3: assert property (@(posedge clk) disable iff (rst)
        day_wrap |-> update_done);

    p_freeze_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        $past(frozen) |-> !update_done);

    p_hold_no_uip_r5: assert property (@(posedge clk) disable iff (rst)
        div_hold |-> !uip);

    p_hold_no_update_r5: assert property (@(posedge clk) disable iff (rst)
        $past(div_hold) |-> !update_done);

    p_uip_before_update_r6: assert property (@(posedge clk) disable iff (rst)
        update_done |-> $past(uip));

    p_alarm_with_update_r9: assert property (@(posedge clk) disable iff (rst)
        alarm_hit |-> update_done);
endmodule

bind tod_clock_core tod_clock_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .frozen     (frozen),
    .div_hold   (div_hold),
    .uip        (uip),
    .update_done(update_done),
    .alarm_hit  (alarm_hit),
    .day_wrap   (day_wrap)
);

// File: tb/tod_clock_core_bench.sv
module tod_clock_core_bench;
    localparam int TPS = 64;
    localparam int UIPT = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_32k = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       uip, update_done, alarm_hit, day_wrap;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    tod_clock_core #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) u_tod_clock_core (
        .clk(clk), .rst(rst), .tick_32k(tick_32k), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .uip(uip),
        .update_done(update_done), .alarm_hit(alarm_hit), .day_wrap(day_wrap)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // {ctlb, wr addr (F = none), wr data, rd addr, expected, requirement}
    localparam logic [35:0] VEC [14] = '{
        {8'h82, 4'h0, 8'h45, 4'h0, 8'h45, 4'd7},  // R7 BCD seconds
        {8'h86, 4'hF, 8'h00, 4'h0, 8'h2D, 4'd7},  // R7 binary view of 45
        {8'h86, 4'h2, 8'h3B, 4'h2, 8'h3B, 4'd7},
        {8'h82, 4'hF, 8'h00, 4'h2, 8'h59, 4'd7},
        {8'h82, 4'h4, 8'h15, 4'h4, 8'h15, 4'd7},
        {8'h80, 4'hF, 8'h00, 4'h4, 8'h83, 4'd8},  // R8 15h -> 3 PM
        {8'h84, 4'hF, 8'h00, 4'h4, 8'h83, 4'd8},
        {8'h80, 4'h4, 8'h12, 4'h4, 8'h12, 4'd8},  // R8 12 AM
        {8'h82, 4'hF, 8'h00, 4'h4, 8'h00, 4'd8},
        {8'h80, 4'h4, 8'h92, 4'h4, 8'h92, 4'd8},  // R8 12 PM
        {8'h82, 4'hF, 8'h00, 4'h4, 8'h12, 4'd8},
        {8'h80, 4'h4, 8'h81, 4'h4, 8'h81, 4'd8},
        {8'h86, 4'hF, 8'h00, 4'h4, 8'h0D, 4'd8},
        {8'h82, 4'h1, 8'hC5, 4'h1, 8'hC5, 4'd9}   // R9 raw alarm readback
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_upd(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!update_done && n < 2000);
        if (n >= 2000) check(1'b0, "watchdog-update", n, 0);
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(3'd4, h); wr(3'd2, m); wr(3'd0, s);
    endtask

    initial begin
        #(20 * 190000);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n, u, c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(3'd6, d); check(d == 8'h20, "R1 ctla", d, 8'h20);
        rd(3'd7, d); check(d == 8'h02, "R1 ctlb", d, 8'h02);
        rd(3'd0, d); check(d == 8'h00, "R1 sec", d, 0);
        check({update_done, alarm_hit, day_wrap, uip} == 4'b0, "R1 strobes",
              {update_done, alarm_hit, day_wrap, uip}, 0);

        foreach (VEC[i]) begin
            wr(3'd7, VEC[i][35:28]);
            if (VEC[i][27:24] != 4'hF) wr(VEC[i][26:24], VEC[i][23:16]);
            rd(VEC[i][14:12], d);
            check(d == VEC[i][11:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i),
                  d, VEC[i][11:4]);
        end

        tick_32k = 1'b1;
        // R2 cadence and pulse width
        wr(3'd7, 8'h82); set_time(8'h00, 8'h00, 8'h10); wr(3'd7, 8'h02);
        wait_upd(n);
        rd(3'd0, d); check(d == 8'h11, "R2 sec advance", d, 8'h11);
        wait_upd(n);
        check(n == TPS, "R2 interval", n, TPS);
        @(negedge clk);
        check(!update_done, "R2 pulse width", update_done, 0);
        // R6 UIP window
        u = 0;
        do begin @(negedge clk); if (uip) u++; end while (!update_done);
        check(u == UIPT, "R6 uip length", u, UIPT);
        wr(3'd6, 8'hA0);
        rd(3'd6, d); check(d == 8'h20, "R6 uip not writable", d, 8'h20);
        repeat (TPS - 4) @(negedge clk);
        rd(3'd6, d); check(d == 8'hA0, "R6 uip readable", d, 8'hA0);
        // R4 freeze and phase keeping
        wait_upd(n); c0 = cyc;
        wr(3'd7, 8'h82); wr(3'd0, 8'h30);
        u = 0;
        repeat (3 * TPS) begin @(negedge clk); if (update_done) u++; end
        check(u == 0, "R4 no update while frozen", u, 0);
        rd(3'd0, d); check(d == 8'h30, "R4 value held", d, 8'h30);
        wr(3'd7, 8'h02);
        wait_upd(n);
        check((cyc - c0) % TPS == 0, "R4 phase kept", (cyc - c0) % TPS, 0);
        rd(3'd0, d); check(d == 8'h31, "R4 resumes", d, 8'h31);
        // R3 day rollover, 24h
        wr(3'd7, 8'h82); set_time(8'h23, 8'h59, 8'h59); wr(3'd7, 8'h02);
        wait_upd(n);
        check(day_wrap, "R3 day_wrap", day_wrap, 1);
        rd(3'd4, d); check(d == 8'h00, "R3 hour wrap", d, 0);
        rd(3'd2, d); check(d == 8'h00, "R3 min wrap", d, 0);
        wait_upd(n);
        check(!day_wrap, "R3 no day_wrap", day_wrap, 0);
        // R8 12h rollover 11 PM -> 12 AM
        wr(3'd7, 8'h80); set_time(8'h91, 8'h59, 8'h59); wr(3'd7, 8'h00);
        wait_upd(n);
        rd(3'd4, d); check(d == 8'h12, "R8 12 AM after wrap", d, 8'h12);
        check(day_wrap, "R3 day_wrap 12h", day_wrap, 1);
        // R5 divider hold and release
        wr(3'd7, 8'h02); wr(3'd6, 8'h60);
        rd(3'd0, d);
        u = 0; c0 = 0;
        repeat (3 * TPS) begin @(negedge clk); if (update_done) u++; if (uip) c0++; end
        check(u == 0, "R5 no update in hold", u, 0);
        check(c0 == 0, "R5 uip low in hold", c0, 0);
        begin
            logic [7:0] d2;
            rd(3'd0, d2); check(d2 == d, "R5 time unchanged", d2, d);
        end
        wr(3'd6, 8'h20);
        wait_upd(n);
        check(n == TPS / 2, "R5 half second", n, TPS / 2);
        // R9 alarm match and wildcard
        wr(3'd7, 8'h82); set_time(8'h10, 8'h20, 8'h30);
        wr(3'd5, 8'h10); wr(3'd3, 8'h20); wr(3'd1, 8'h31); wr(3'd7, 8'h02);
        wait_upd(n); check(alarm_hit, "R9 exact match", alarm_hit, 1);
        wait_upd(n); check(!alarm_hit, "R9 no match", alarm_hit, 0);
        wr(3'd7, 8'h82); wr(3'd1, 8'hC0); wr(3'd7, 8'h02);
        wait_upd(n); check(alarm_hit, "R9 wildcard seconds", alarm_hit, 1);
        wr(3'd7, 8'h82); wr(3'd3, 8'h21); wr(3'd7, 8'h02);
        wait_upd(n); check(!alarm_hit, "R9 minute mismatch", alarm_hit, 0);
        // R10 12h alarm hour against 24h time
        wr(3'd7, 8'h80); set_time(8'h82, 8'h00, 8'h00);
        wr(3'd5, 8'h82); wr(3'd3, 8'h00); wr(3'd1, 8'h01); wr(3'd7, 8'h00);
        wait_upd(n); check(alarm_hit, "R10 2 PM matches 14h", alarm_hit, 1);
        wr(3'd7, 8'h80); wr(3'd0, 8'h00); wr(3'd5, 8'h02); wr(3'd7, 8'h00);
        wait_upd(n); check(!alarm_hit, "R10 2 AM no match", alarm_hit, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule